// File: doc/BRIEF.md
# Paired Stochastic Bitstream Source for Image Multiplication

This block turns two sets of sixteen 5-bit pixel intensities, one set per image, into sixteen pairs of unipolar stochastic bitstreams, one new bit per stream per time slot. A single free-running 34-bit linear feedback shift register is the only source of randomness. Two disjoint groups of five of its stages form two random levels, each from 0 to 31. Every intensity of the first image is compared against the first level and every intensity of the second image against the second level. A stream bit is 1 exactly when the intensity is strictly above the level, so the long-run density of ones in a stream is intensity/32.

A downstream stage ANDs the two streams of one grid point to form the stochastic product of the two images. Because the two levels come from non-overlapping register stages, the two streams of a grid point are statistically independent. The register advances only in cycles where the slot enable is high, and a synchronous active-low reset loads a fixed nonzero seed.

Top module: `stoch_pair_gen`

## Requirements
- R1: In each clock cycle with `slot_en` high and `rst_n` high, the register shifts one place toward its most significant bit, and bit 0 takes the XOR of bits 33, 26, 1 and 0 (stages 34, 27, 2 and 1).
- R2: After reset the register never holds the all-zero word, so the random levels keep changing for as long as slots are issued.
- R3: In a cycle with `slot_en` low and `rst_n` high, the register keeps its value, so both random levels and all stream outputs for unchanged intensities stay the same.
- R4: A clock edge with `rst_n` low loads the seed parameter (default 34'h1_2345_6789) into the register, whatever `slot_en` is.
- R5: Level A is formed from register bits 0, 7, 14, 21, 28 (bit 0 as its LSB, bit 28 as its MSB) and level B from bits 3, 10, 17, 24, 31 in the same order; the two sets share no stage.
- R6: Stream bit `str_a[i]` is 1 exactly when intensity field i of `pix_a` (bits 5i+4 down to 5i) is strictly greater than level A, and likewise `str_b[i]` against level B; the outputs follow the current register state and the current intensities without a register stage.
- R7: An intensity of 0 gives a stream bit of 0 in every slot.
- R8: An intensity of 31 gives a stream bit of 1 in every slot except those where the level equals 31.
- R9: All sixteen streams of one image are compared against the same level, so equal intensities give identical bits in a slot; over many slots the two streams of one grid point agree with independence (with both intensities 16, the joint-one count is near a quarter of the slots).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the seed |
| slot_en | input | 1 | Advances the register by one time slot when high |
| pix_a | input | 80 | Image A intensities, point i in bits 5i+4:5i |
| pix_b | input | 80 | Image B intensities, point i in bits 5i+4:5i |
| str_a | output | 16 | Image A stream bits for the current slot |
| str_b | output | 16 | Image B stream bits for the current slot |

## Verification
The hardest conditions to reach from the ports are the extreme random levels: a level of exactly 31 is the only thing that turns off a full-scale stream, and it only appears when five specific register stages are all ones. The bench does not force it; it runs thousands of slots with full-scale and thermometer-coded intensities, tracks the register in a behavioural model, counts how often each extreme level occurs and requires that level 31 was actually hit. Independence of the two images is checked statistically by counting joint ones over a long run at half-scale intensity.

// File: rtl/stoch_pkg.sv
// Package stoch_pkg
// Shared sizes, default feedback taps, seed and field placement for the
// paired stochastic bitstream source. Assumes a 34-stage register.
package stoch_pkg;

    localparam int          SR_W      = 34;
    localparam int          LVL_W     = 5;
    localparam int          N_PTS     = 16;

    // Feedback stages 34, 27, 2, 1 expressed as bit indices 33, 26, 1, 0.
    localparam logic [SR_W-1:0] FB_MASK  = 34'h2_0400_0003;
    localparam logic [SR_W-1:0] SR_SEED  = 34'h1_2345_6789;

    // Level fields: stage index = base + k*stride, k = 0 is the LSB.
    localparam int          LVLA_BASE = 0;
    localparam int          LVLB_BASE = 3;
    localparam int          LVL_STEP  = 7;

    typedef logic [LVL_W-1:0] level_t;

endpackage

// File: rtl/stoch_lfsr.sv
// Module stoch_lfsr
// Fibonacci shift register that moves one place toward its MSB on every
// enabled slot; the new bit 0 is the XOR of the stages selected by FB_MASK.
// Assumes FB_MASK describes a maximal-length polynomial and SEED is nonzero.
module stoch_lfsr #(
    parameter int               W       = 34,
    parameter logic [W-1:0]     FB_MASK = '1,
    parameter logic [W-1:0]     SEED    = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state
);

    logic [W-1:0] state_q;
    logic         fb_bit;

    // Parity of the tapped stages forms the incoming bit.
    always_comb begin
        fb_bit = ^(state_q & FB_MASK);
    end

    // Register update: seed on reset, shift on enabled slot, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (adv) begin
            state_q <= {state_q[W-2:0], fb_bit};
        end
    end

    assign state = state_q;

    // A maximal-length register has no fixed point apart from zero.
    assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (state_q != $past(state_q)));

    // Older bits move up by one place on an enabled slot.
    assert_shift_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (state_q[W-1:1] == $past(state_q[W-2:0])));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_q));

    assert_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (state_q == SEED));

endmodule

// File: rtl/stoch_cmp_bank.sv
// Module stoch_cmp_bank
// N_PTS magnitude comparators sharing one random level. Each output bit is
// high when its intensity is strictly above the level. Purely combinational;
// clk and rst_n only time the local assertions.
module stoch_cmp_bank #(
    parameter int N_PTS = 16,
    parameter int LVL_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LVL_W-1:0]       level,
    input  logic [N_PTS*LVL_W-1:0] pix,
    output logic [N_PTS-1:0]       bits
);

    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

    genvar gi;
    generate
        for (gi = 0; gi < N_PTS; gi++) begin : g_pt
            logic [LVL_W-1:0] val;

            // Slice this point's intensity out of the packed array.
            always_comb begin
                val = pix[gi*LVL_W +: LVL_W];
            end

            // Strict comparison against the shared level.
            always_comb begin
                bits[gi] = (val > level);
            end

            assert_zero_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (val == '0) |-> !bits[gi]);

            assert_full_bright_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ((val == LVL_MAX) && (level != LVL_MAX)) |-> bits[gi]);

            assert_top_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (level == LVL_MAX) |-> !bits[gi]);
        end
    endgenerate

endmodule

// File: rtl/stoch_pair_gen.sv
// Module stoch_pair_gen
// Top of the paired stochastic bitstream source. One shift register feeds
// two random levels taken from disjoint stage sets; each level drives one
// bank of comparators for one image. Assumes the field placement parameters
// keep both sets inside the register and apart from each other.
module stoch_pair_gen
    import stoch_pkg::*;
#(
    parameter int               SR_W_P   = SR_W,
    parameter int               LVL_W_P  = LVL_W,
    parameter int               N_PTS_P  = N_PTS,
    parameter logic [SR_W_P-1:0] FB_P    = FB_MASK,
    parameter logic [SR_W_P-1:0] SEED_P  = SR_SEED,
    parameter int               A_BASE_P = LVLA_BASE,
    parameter int               B_BASE_P = LVLB_BASE,
    parameter int               STEP_P   = LVL_STEP
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       slot_en,
    input  logic [N_PTS_P*LVL_W_P-1:0] pix_a,
    input  logic [N_PTS_P*LVL_W_P-1:0] pix_b,
    output logic [N_PTS_P-1:0]         str_a,
    output logic [N_PTS_P-1:0]         str_b
);

    localparam int A_TOP = A_BASE_P + (LVL_W_P-1)*STEP_P;
    localparam int B_TOP = B_BASE_P + (LVL_W_P-1)*STEP_P;

    logic [SR_W_P-1:0]  sr_word;
    logic [LVL_W_P-1:0] lvl_a;
    logic [LVL_W_P-1:0] lvl_b;

    // Random source shared by both images.
    stoch_lfsr #(
        .W       (SR_W_P),
        .FB_MASK (FB_P),
        .SEED    (SEED_P)
    ) u_sr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (slot_en),
        .state (sr_word)
    );

    // Gather the two level fields from strided stages.
    genvar gk;
    generate
        for (gk = 0; gk < LVL_W_P; gk++) begin : g_fld
            assign lvl_a[gk] = sr_word[A_BASE_P + gk*STEP_P];
            assign lvl_b[gk] = sr_word[B_BASE_P + gk*STEP_P];
        end
    endgenerate

    // Comparator bank for image A.
    stoch_cmp_bank #(
        .N_PTS (N_PTS_P),
        .LVL_W (LVL_W_P)
    ) u_bank_a (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lvl_a),
        .pix   (pix_a),
        .bits  (str_a)
    );

    // Comparator bank for image B.
    stoch_cmp_bank #(
        .N_PTS (N_PTS_P),
        .LVL_W (LVL_W_P)
    ) u_bank_b (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lvl_b),
        .pix   (pix_b),
        .bits  (str_b)
    );

    // Placement sanity, evaluated once the clock runs.
    always_comb begin
        assert_fields_fit_R5: assert ((A_TOP < SR_W_P) && (B_TOP < SR_W_P));
    end

    assert_never_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sr_word != '0);

    assert_streams_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_en && $stable(pix_a) && $stable(pix_b)) |=>
            ($stable(str_a) || !$stable(pix_a)) && ($stable(str_b) || !$stable(pix_b)));

endmodule

// File: tb/sim_stoch_pair_gen.sv
`timescale 1ns/1ps
module sim_stoch_pair_gen;

    localparam int PW = 5;
    localparam int NP = 16;
    localparam logic [33:0] SEED = 34'h1_2345_6789;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             slot_en = 1'b0;
    logic [NP*PW-1:0] pix_a = '0;
    logic [NP*PW-1:0] pix_b = '0;
    logic [NP-1:0]    str_a;
    logic [NP-1:0]    str_b;

    int total = 0;
    int bad   = 0;
    logic [33:0] m;          // behavioural copy of the register word
    bit   done = 0;

    always #5 clk = ~clk;

    stoch_pair_gen u0 (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en),
        .pix_a(pix_a), .pix_b(pix_b), .str_a(str_a), .str_b(str_b)
    );

    function automatic logic [33:0] nxt(input logic [33:0] s);
        return {s[32:0], s[33] ^ s[26] ^ s[1] ^ s[0]};
    endfunction

    function automatic int lvl(input logic [33:0] s, input int base);
        int v = 0;
        for (int k = 0; k < 5; k++) if (s[base + 7*k]) v += (1 << k);
        return v;
    endfunction

    function automatic logic [NP-1:0] expect_bits(input logic [NP*PW-1:0] p, input int l);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) r[i] = (int'(p[i*PW +: PW]) > l);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int got, input int lo, input int hi);
        total++;
        if (got < lo || got > hi) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
        end
    endtask

    // One clock: drive at negedge, compare, then follow the edge in the model.
    task automatic step(input string tag, input logic en, input logic rn,
                        input logic [NP*PW-1:0] a, input logic [NP*PW-1:0] b);
        @(negedge clk);
        slot_en = en; rst_n = rn; pix_a = a; pix_b = b;
        #1;
        chk({tag, " A"}, str_a, expect_bits(a, lvl(m, 0)));
        chk({tag, " B"}, str_b, expect_bits(b, lvl(m, 3)));
        @(posedge clk);
        #1;
        if (!rn) m = SEED;
        else if (en) m = nxt(m);
    endtask

    function automatic logic [NP*PW-1:0] fill(input int v);
        logic [NP*PW-1:0] r;
        for (int i = 0; i < NP; i++) r[i*PW +: PW] = PW'(v);
        return r;
    endfunction

    function automatic logic [NP*PW-1:0] ramp(input int off);
        logic [NP*PW-1:0] r;
        for (int i = 0; i < NP; i++) r[i*PW +: PW] = PW'(2*i + off);
        return r;
    endfunction

    function automatic logic [NP*PW-1:0] rnd();
        logic [NP*PW-1:0] r;
        for (int i = 0; i < NP; i++) r[i*PW +: PW] = PW'($urandom_range(31, 0));
        return r;
    endfunction

    initial begin
        int hits31, joint, ones_a;
        logic [NP-1:0] first_a;
        bit varied;
        // Reset: two edges with rst_n low load the seed (R4).
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 m = SEED;
        step("R4 reset hold", 1'b1, 1'b0, ramp(0), ramp(1));
        step("R4 reset hold", 1'b0, 1'b0, ramp(1), ramp(0));

        // Thermometer inputs reveal the field placement (R5, R1).
        for (int c = 0; c < 300; c++)
            step("R5 ramp", 1'b1, 1'b1, ramp(c % 2), ramp(1 - c % 2));

        // Enable low: register must hold while intensities change (R3).
        for (int c = 0; c < 40; c++)
            step("R3 hold", 1'b0, 1'b1, rnd(), rnd());

        // Random intensities, random enable (R6, R1).
        for (int c = 0; c < 1500; c++)
            step("R6 random", ($urandom_range(3, 0) != 0), 1'b1, rnd(), rnd());

        // Dark pixels (R7).
        for (int c = 0; c < 200; c++) begin
            step("R7 dark", 1'b1, 1'b1, fill(0), fill(0));
            total++;
            if (str_a !== '0 || str_b !== '0) begin
                bad++;
                $display("FAIL R7: got %h/%h expected 0", str_a, str_b);
            end
        end

        // Full-scale pixels; count level-31 slots on image A (R8).
        hits31 = 0;
        for (int c = 0; c < 2048; c++) begin
            if (lvl(m, 0) == 31) hits31++;
            step("R8 full", 1'b1, 1'b1, fill(31), fill(31));
        end
        chk_int("R8 level 31 reached", hits31, 1, 2048);

        // Mid-run reset reloads the seed (R4).
        step("R4 mid reset", 1'b1, 1'b0, ramp(0), ramp(1));
        step("R4 after reset", 1'b0, 1'b1, ramp(0), ramp(1));

        // Half-scale: shared level and independence (R9), no lock-up (R2).
        joint = 0; ones_a = 0; varied = 0;
        for (int c = 0; c < 4096; c++) begin
            step("R9 half", 1'b1, 1'b1, fill(16), fill(16));
            if (c == 0) first_a = str_a;
            else if (str_a !== first_a) varied = 1;
            total++;
            if (str_a !== '0 && str_a !== '1) begin
                bad++;
                $display("FAIL R9: got %h expected all-equal bits", str_a);
            end
            if (str_a[5]) ones_a++;
            if (str_a[5] && str_b[5]) joint++;
        end
        chk_int("R9 marginal ones", ones_a, 2048 - 192, 2048 + 192);
        chk_int("R9 joint ones", joint, 1024 - 128, 1024 + 128);
        chk_int("R2 levels keep moving", int'(varied), 1, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1_500_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule